// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three motor phases, each with a high-side and a low-side output, from a symmetric triangular carrier. Dead time separates the two outputs of each phase. Software writes a set of buffered settings through a narrow write port: an upper compare value, a half-period value, a dead-time value, three duty values and the output polarity.

When the mode-enable input rises, the five buffered compare settings are copied into the active compare registers on one clock edge. Two counters then start at different values. The lower counter starts at 0 and the upper counter starts at the dead time. Both step up and down together, so they stay exactly one dead time apart. A phase's high-side output is active while the lower counter is at or above that phase's duty. Its low-side output is active while the upper counter is below the duty. This leaves a gap of dead-time cycles in which neither output is active.

While the mode is off, all outputs sit at their inactive level. The polarity setting can be changed only while the mode is off.

Top module: `cpwm_top`

## Requirements
- R1: Writes with `wrEn` high store `wrData` at the addressed register on the clock edge. The address map is: 0 upper compare buffer, 1 half-period buffer, 2 dead time, 3/4/5 duty buffers of phases 0/1/2, 6 polarity.
- R2: On the first clock edge where `modeEn` is sampled high after being low, all five buffers are copied into the active registers at once. A buffer write made on that same edge is not copied, and buffer writes made while running have no effect on the outputs until the next enable.
- R3: At start the lower counter is 0 and the upper counter equals the dead time. On each later enabled edge, both counters go up by one or both go down by one. The direction turns to down when the lower counter reaches the half-period or the upper counter reaches the upper compare value. It turns to up when the lower counter reaches 0.
- R4: A phase's positive output is active when the lower counter is greater than or equal to its duty. Its negative output is active when the upper counter is less than its duty. Each output is registered and so lags the counters by one clock.
- R5: The positive and negative outputs of one phase are never active together. With a dead time of 0 they are exactly complementary.
- R6: A duty of 0 holds the positive output constantly active and the negative output constantly inactive. A duty greater than the upper compare value holds the positive output inactive and the negative output active.
- R7: Reset, or `modeEn` sampled low, stops the counters. One clock later every output is at its inactive level.
- R8: Polarity bit 0 is the active level of all positive outputs and bit 1 is the active level of all negative outputs (1 means active high); the reset value is 3. A polarity write made while `modeEn` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| modeEn | input | 1 | Complementary PWM mode enable |
| pwmPos | output | 3 | Positive (high-side) outputs, one per phase |
| pwmNeg | output | 3 | Negative (low-side) outputs, one per phase |

## Verification
The bench targets the following cases, each with the failure it would expose:

- **Write on the enable edge.** A duty write lands on the same edge that enables the mode. A design that copied the new buffer value would switch one phase at the wrong counts for the whole run.
- **Writes while running.** Duty and polarity writes are made during a run. A design that forwarded them would change pulse widths or flip the levels immediately.
- **Zero dead time.** A design with an off-by-one in the compares would overlap both outputs or leave a one-cycle gap.
- **Duty of 0 and duty above the upper compare.** A design that compared with the wrong inequality would emit a one-cycle glitch at the trough or at the peak.
- **Minimal carrier.** A half-period of 1 would expose a wrong turning rule as a stuck or wrapping counter.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // strobes passed from the control to the datapath
  typedef struct packed {
    logic load;   // copy buffers into active registers, restart counters
    logic step;   // advance the carrier by one count
    logic clear;  // hold counters at zero
    logic run;    // mode is running
  } cpwmStb_t;
endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PH = 3,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic             modeEn,
  output cpwmStb_t         stb,
  output logic [DW-1:0]    peakBuf,
  output logic [DW-1:0]    halfBuf,
  output logic [DW-1:0]    deadReg,
  output logic [PH*DW-1:0] dutyBuf,
  output logic             posLvl,
  output logic             negLvl
);
  localparam int ADDR_PEAK  = 0;
  localparam int ADDR_HALF  = 1;
  localparam int ADDR_DEAD  = 2;
  localparam int ADDR_DUTY0 = 3;
  localparam int ADDR_POL   = ADDR_DUTY0 + PH;

  logic runQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runQ <= 1'b0;
    else        runQ <= modeEn;
  end

  always_comb begin
    stb.load  = modeEn & ~runQ;
    stb.step  = modeEn & runQ;
    stb.clear = ~modeEn;
    stb.run   = runQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peakBuf <= '0;
      halfBuf <= '0;
      deadReg <= '0;
      posLvl  <= 1'b1;
      negLvl  <= 1'b1;
    end else if (wrEn) begin
      if (wrAddr == AW'(ADDR_PEAK)) peakBuf <= wrData;
      if (wrAddr == AW'(ADDR_HALF)) halfBuf <= wrData;
      if (wrAddr == AW'(ADDR_DEAD)) deadReg <= wrData;
      if (wrAddr == AW'(ADDR_POL) && !modeEn) begin
        posLvl <= wrData[0];
        negLvl <= wrData[1];
      end
    end
  end

  for (genvar p = 0; p < PH; p++) begin : g_duty
    logic [DW-1:0] dutyQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dutyQ <= '0;
      else if (wrEn && wrAddr == AW'(ADDR_DUTY0 + p)) dutyQ <= wrData;
    end
    assign dutyBuf[p*DW +: DW] = dutyQ;
  end

  // R8: polarity cannot move while the mode input is high
  a_r8_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
    modeEn |=> ($stable(posLvl) && $stable(negLvl)));

  // R2: the load strobe is a single pulse at the start of a run
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> !stb.load);
endmodule

// File: rtl/cpwm_dp.sv
module cpwm_dp
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cpwmStb_t         stb,
  input  logic [DW-1:0]    peakBuf,
  input  logic [DW-1:0]    halfBuf,
  input  logic [DW-1:0]    deadReg,
  input  logic [PH*DW-1:0] dutyBuf,
  input  logic             posLvl,
  input  logic             negLvl,
  output logic [PH-1:0]    pwmPos,
  output logic [PH-1:0]    pwmNeg
);
  logic [DW-1:0]    cntLo, cntHi, peakAct, halfAct;
  logic [PH*DW-1:0] dutyAct;
  logic             dirUp;
  logic [DW-1:0]    loInc, hiInc, loDec, hiDec;
  logic [PH-1:0]    posAct, negAct;

  assign loInc = cntLo + 1'b1;
  assign hiInc = cntHi + 1'b1;
  assign loDec = cntLo - 1'b1;
  assign hiDec = cntHi - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peakAct <= '0;
      halfAct <= '0;
      dutyAct <= '0;
    end else if (stb.load) begin
      peakAct <= peakBuf;
      halfAct <= halfBuf;
      dutyAct <= dutyBuf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntLo <= '0;
      cntHi <= '0;
      dirUp <= 1'b1;
    end else if (stb.load) begin
      cntLo <= '0;
      cntHi <= deadReg;
      dirUp <= 1'b1;
    end else if (stb.step) begin
      if (dirUp) begin
        cntLo <= loInc;
        cntHi <= hiInc;
        if (loInc == halfAct || hiInc == peakAct) dirUp <= 1'b0;
      end else begin
        cntLo <= loDec;
        cntHi <= hiDec;
        if (loDec == '0) dirUp <= 1'b1;
      end
    end else if (stb.clear) begin
      cntLo <= '0;
      cntHi <= '0;
      dirUp <= 1'b1;
    end
  end

  for (genvar p = 0; p < PH; p++) begin : g_phase
    logic [DW-1:0] duty;
    assign duty      = dutyAct[p*DW +: DW];
    assign posAct[p] = stb.run && (cntLo >= duty);
    assign negAct[p] = stb.run && (cntHi < duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmPos <= '0;
      pwmNeg <= '0;
    end else begin
      for (int p = 0; p < PH; p++) begin
        pwmPos[p] <= posAct[p] ? posLvl : ~posLvl;
        pwmNeg[p] <= negAct[p] ? negLvl : ~negLvl;
      end
    end
  end

  // R5: never both sides of one phase active
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (posAct & negAct) == '0);

  // R3: every running step moves the lower counter by exactly one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |=> (cntLo == DW'($past(cntLo) + 1'b1) || cntLo == DW'($past(cntLo) - 1'b1)));

  // R2: duties of the new run equal the buffers seen at the enable edge
  a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> (dutyAct == $past(dutyBuf) && peakAct == $past(peakBuf)));

  // R7: outputs idle one clock after a non-running cycle
  a_r7_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.run |=> (pwmPos == {PH{~$past(posLvl)}} && pwmNeg == {PH{~$past(negLvl)}}));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PH = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          modeEn,
  output logic [PH-1:0] pwmPos,
  output logic [PH-1:0] pwmNeg
);
  cpwmStb_t         stb;
  logic [DW-1:0]    peakBuf, halfBuf, deadReg;
  logic [PH*DW-1:0] dutyBuf;
  logic             posLvl, negLvl;

  cpwm_ctrl #(.DW(DW), .PH(PH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeEn(modeEn), .stb(stb), .peakBuf(peakBuf), .halfBuf(halfBuf),
    .deadReg(deadReg), .dutyBuf(dutyBuf), .posLvl(posLvl), .negLvl(negLvl)
  );

  cpwm_dp #(.DW(DW), .PH(PH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .peakBuf(peakBuf), .halfBuf(halfBuf),
    .deadReg(deadReg), .dutyBuf(dutyBuf), .posLvl(posLvl), .negLvl(negLvl),
    .pwmPos(pwmPos), .pwmNeg(pwmNeg)
  );
endmodule

// File: tb/sim_cpwm_top.sv
module sim_cpwm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic       modeEn = 1'b0;
  logic [2:0] pwmPos, pwmNeg;

  cpwm_top u0 (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
               .wrData(wrData), .modeEn(modeEn), .pwmPos(pwmPos), .pwmNeg(pwmNeg));

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit chkOn = 1'b0;
  string curReq = "R7";

  // behavioural reference model
  int bPeak, bHalf, bDead, bPol;
  int bDuty[3];
  int aPeak, aHalf;
  int aDuty[3];
  bit mRun, mUp;
  int lo, hi;
  logic [2:0] expPos, expNeg;

  always @(posedge clk) begin
    if (!rst_n) begin
      bPeak = 0; bHalf = 0; bDead = 0; bPol = 3;
      aPeak = 0; aHalf = 0; mRun = 0; mUp = 1; lo = 0; hi = 0;
      for (int p = 0; p < 3; p++) begin bDuty[p] = 0; aDuty[p] = 0; end
      expPos = '0; expNeg = '0;
    end else begin
      // registered outputs reflect the state before this edge
      for (int p = 0; p < 3; p++) begin
        bit pa, na;
        pa = mRun && (lo >= aDuty[p]);
        na = mRun && (hi < aDuty[p]);
        expPos[p] = pa ? bPol[0] : !bPol[0];
        expNeg[p] = na ? bPol[1] : !bPol[1];
      end
      if (modeEn && !mRun) begin
        aPeak = bPeak; aHalf = bHalf;
        for (int p = 0; p < 3; p++) aDuty[p] = bDuty[p];
        lo = 0; hi = bDead; mUp = 1; mRun = 1;
      end else if (modeEn && mRun) begin
        if (mUp) begin
          lo++; hi++;
          if (lo == aHalf || hi == aPeak) mUp = 0;
        end else begin
          lo--; hi--;
          if (lo == 0) mUp = 1;
        end
      end else begin
        mRun = 0; lo = 0; hi = 0; mUp = 1;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: bPeak = int'(wrData);
          3'd1: bHalf = int'(wrData);
          3'd2: bDead = int'(wrData);
          3'd3, 3'd4, 3'd5: bDuty[int'(wrAddr) - 3] = int'(wrData);
          3'd6: if (!modeEn) bPol = int'(wrData[1:0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      checks++;
      if (pwmPos !== expPos || pwmNeg !== expNeg) begin
        errors++;
        $display("FAIL %s: pos=%b neg=%b expected pos=%b neg=%b", curReq, pwmPos, pwmNeg, expPos, expNeg);
      end
      // R5: decode activity from the observed levels
      checks++;
      if (((pwmPos ~^ {3{bPol[0] == 1}}) & (pwmNeg ~^ {3{bPol[1] == 1}})) != 3'b000 && mRun) begin
        errors++;
        $display("FAIL R5: both sides active pos=%b neg=%b expected no overlap", pwmPos, pwmNeg);
      end
    end
  end

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    checks++;  // R7 reset state
    if (pwmPos !== 3'b000 || pwmNeg !== 3'b000) begin
      errors++;
      $display("FAIL R7: reset pos=%b neg=%b expected pos=000 neg=000", pwmPos, pwmNeg);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chkOn = 1'b1;

    curReq = "R1";
    wr(0, 12); wr(1, 8); wr(2, 4); wr(3, 2); wr(4, 5); wr(5, 9);
    curReq = "R4"; modeEn = 1'b1; idle(40);
    curReq = "R3"; idle(40);
    curReq = "R2"; wr(3, 7); wr(4, 1); idle(10);
    curReq = "R8"; wr(6, 0); idle(30);
    curReq = "R7"; modeEn = 1'b0; idle(5);
    curReq = "R8"; wr(6, 1); idle(3);

    curReq = "R2";  // write on the enable edge must not be copied
    modeEn = 1'b1; wr(3, 3); idle(40);

    curReq = "R5";
    modeEn = 1'b0; idle(2);
    wr(2, 0); wr(0, 8); wr(1, 8); wr(6, 3);
    modeEn = 1'b1; idle(40);

    curReq = "R6";
    modeEn = 1'b0; idle(2);
    wr(0, 8); wr(1, 5); wr(2, 3); wr(3, 0); wr(4, 9); wr(5, 20);
    modeEn = 1'b1; idle(40);

    curReq = "R3";  // minimal carrier
    modeEn = 1'b0; idle(2);
    wr(0, 1); wr(1, 1); wr(2, 0); wr(3, 1); wr(4, 0); wr(5, 1);
    modeEn = 1'b1; idle(20);
    curReq = "R7"; modeEn = 1'b0; idle(4);

    chkOn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule